// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a combinational integer datapath that keeps results inside their representable range instead of letting them wrap. Each cycle it takes an opcode, two operands and a saturation width. It returns a result in the same cycle. The operations are:

- signed and unsigned add and subtract, each with saturation;
- signed doubling;
- clamping of a value to a chosen signed or unsigned bit width, applied either to the whole word or to each half-word on its own.

A single sticky flag records that some operation had to limit its result. The flag is registered on the rising clock edge. It stays set until a synchronous clear request removes it. Software reads it after a run of operations to learn whether any of them lost precision.

The data width is a parameter, with a default of 32 bits. In the text below, MAX and MIN are the largest and smallest signed values of that width (0x7FFFFFFF and 0x80000000 at the default). HALF is half the data width.

Top module: `sat_alu`

## Requirements
- R1: With opcode 1 (signed add), when the two operands share a sign and the sign of the raw sum differs from opA, the result is MAX for non-negative opA and MIN for negative opA, and that is a saturation; otherwise the result is the wrapped sum.
- R2: With opcode 2 (signed subtract, opA minus opB), when the operands differ in sign and the sign of the raw difference differs from opA, the result is MAX or MIN by the sign of opA, and that is a saturation; otherwise the result is the wrapped difference.
- R3: With opcode 3 (signed doubling of opA), an opA of at least 2^(W-2) gives MAX and an opA of at most -2^(W-2) gives MIN. Both count as a saturation, and this includes an opA of exactly -2^(W-2), whose doubled value MIN is itself representable. Any other opA gives opA shifted left by one.
- R4: With opcode 4 (unsigned add), a sum that carries out of the word gives all ones and counts as a saturation; otherwise the result is the sum.
- R5: With opcode 5 (unsigned subtract), an opB greater than opA gives 0 and counts as a saturation; otherwise the result is opA minus opB.
- R6: With opcode 6 (signed word clamp), opA taken as signed is limited to [-2^(N-1), 2^(N-1)-1]. N is satWidth capped at the data width, and a satWidth of 0 counts as 1. A value that is changed counts as a saturation.
- R7: With opcode 7 (unsigned word clamp), opA taken as signed is limited to [0, 2^N-1]. N is satWidth capped at the data width, and N may be 0. A value that is changed counts as a saturation.
- R8: Opcodes 8 (signed) and 9 (unsigned) apply the clamps of R6 and R7 to each sign-extended HALF-bit half of opA independently, with N capped at HALF. The low HALF bits of each clamped half are packed in place: the low half's result in the low bits and the high half's result in the high bits. A change in either half counts as a saturation.
- R9: The sticky flag is 0 after reset. At a rising clock edge it becomes 1 if the current operation saturates, even when stickyClr is high in that cycle. Otherwise it becomes 0 when stickyClr is high, and otherwise it keeps its value.
- R10: Opcode 0 and opcodes 10 to 15 return opA unchanged, ignore opB and satWidth, and never count as a saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the sticky flag updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 4 | Operation select (see requirements) |
| opA | input | DATA_W | First operand, or the value to clamp |
| opB | input | DATA_W | Second operand |
| satWidth | input | WID_W | Clamp bit width N |
| stickyClr | input | 1 | Synchronous clear request for the sticky flag |
| result | output | DATA_W | Combinational result |
| sticky | output | 1 | Sticky saturation flag |

## Verification
The only state is the sticky flag. A wrong flag is visible at the port one clock edge after the operation that should have set it or cleared it. The bench therefore pairs every vector with a flag check at the next edge, and it holds stickyClr high during the sweeps so that each edge shows the saturation of exactly one vector. A fault in the datapath appears at once on result in the same cycle. Sweeping every operand value of a narrow configuration exposes any wrong comparison boundary, such as the inclusive lower doubling limit or the cap on the clamp width.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_PASS = 4'd0;
  localparam logic [OP_W-1:0] OP_SADD = 4'd1;
  localparam logic [OP_W-1:0] OP_SSUB = 4'd2;
  localparam logic [OP_W-1:0] OP_SDBL = 4'd3;
  localparam logic [OP_W-1:0] OP_UADD = 4'd4;
  localparam logic [OP_W-1:0] OP_USUB = 4'd5;
  localparam logic [OP_W-1:0] OP_SCLW = 4'd6;
  localparam logic [OP_W-1:0] OP_UCLW = 4'd7;
  localparam logic [OP_W-1:0] OP_SCLH = 4'd8;
  localparam logic [OP_W-1:0] OP_UCLH = 4'd9;

  // Strobes from control to datapath
  typedef struct packed {
    logic selSAdd;
    logic selSSub;
    logic selDbl;
    logic selUAdd;
    logic selUSub;
    logic selClamp;
    logic clampHalf;
    logic clampSigned;
  } satStrobe_t;
endpackage

// File: rtl/sat_clamp_lane.sv
module sat_clamp_lane #(
  parameter int W     = 32,
  parameter int WID_W = 6
) (
  input  logic [W-1:0]     val,
  input  logic [WID_W-1:0] width,
  input  logic             isSigned,
  output logic [W-1:0]     res,
  output logic             hit
);
  // Two guard bits keep 2^W-1 positive in the signed compare
  localparam int EW = W + 2;

  int             nEff;
  logic [EW-1:0]  pow;
  logic [EW-1:0]  hiLim;
  logic [EW-1:0]  loLim;
  logic [EW-1:0]  valExt;

  always_comb begin
    nEff = int'(width);
    if (nEff > W) nEff = W;
    if (isSigned && nEff == 0) nEff = 1;
    pow    = {{(EW-1){1'b0}}, 1'b1} << nEff;
    hiLim  = isSigned ? (pow >> 1) - {{(EW-1){1'b0}}, 1'b1} : pow - {{(EW-1){1'b0}}, 1'b1};
    loLim  = isSigned ? (~(pow >> 1) + {{(EW-1){1'b0}}, 1'b1}) : '0;
    valExt = {{2{val[W-1]}}, val};
    res    = val;
    hit    = 1'b0;
    if ($signed(valExt) > $signed(hiLim)) begin
      res = hiLim[W-1:0];
      hit = 1'b1;
    end else if ($signed(valExt) < $signed(loLim)) begin
      res = loLim[W-1:0];
      hit = 1'b1;
    end
  end
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opCode,
  input  logic            satHit,
  input  logic            stickyClr,
  output satStrobe_t      strobe,
  output logic            sticky
);
  always_comb begin
    strobe = '0;
    case (opCode)
      OP_SADD: strobe.selSAdd = 1'b1;
      OP_SSUB: strobe.selSSub = 1'b1;
      OP_SDBL: strobe.selDbl  = 1'b1;
      OP_UADD: strobe.selUAdd = 1'b1;
      OP_USUB: strobe.selUSub = 1'b1;
      OP_SCLW: begin strobe.selClamp = 1'b1; strobe.clampSigned = 1'b1; end
      OP_UCLW: strobe.selClamp = 1'b1;
      OP_SCLH: begin strobe.selClamp = 1'b1; strobe.clampHalf = 1'b1; strobe.clampSigned = 1'b1; end
      OP_UCLH: begin strobe.selClamp = 1'b1; strobe.clampHalf = 1'b1; end
      default: strobe = '0;
    endcase
  end

  // Saturation outranks a same-cycle clear so no event is lost
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          sticky <= 1'b0;
    else if (satHit)    sticky <= 1'b1;
    else if (stickyClr) sticky <= 1'b0;
  end
endmodule

// File: rtl/sat_dp.sv
module sat_dp
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WID_W  = 6
) (
  input  satStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [WID_W-1:0]  satWidth,
  output logic [DATA_W-1:0] result,
  output logic              satHit
);
  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MAX_S = {1'b0, {MSB{1'b1}}};
  localparam logic [DATA_W-1:0] MIN_S = {1'b1, {MSB{1'b0}}};

  logic [DATA_W:0]   addFull;
  logic [DATA_W:0]   subFull;
  logic [DATA_W-1:0] signLim;
  logic              sAddOvf;
  logic              sSubOvf;
  logic              dblHi;
  logic              dblLo;

  assign addFull = {1'b0, opA} + {1'b0, opB};
  assign subFull = {1'b0, opA} - {1'b0, opB};
  assign signLim = opA[MSB] ? MIN_S : MAX_S;
  assign sAddOvf = (opA[MSB] == opB[MSB]) && (addFull[MSB] != opA[MSB]);
  assign sSubOvf = (opA[MSB] != opB[MSB]) && (subFull[MSB] != opA[MSB]);
  assign dblHi   = ~opA[MSB] & opA[MSB-1];
  assign dblLo   = opA[MSB] & (~opA[MSB-1] | ~|opA[MSB-2:0]);

  logic [DATA_W-1:0] wordRes;
  logic              wordHit;

  sat_clamp_lane #(.W(DATA_W), .WID_W(WID_W)) uWordLane (
    .val(opA), .width(satWidth), .isSigned(strobe.clampSigned),
    .res(wordRes), .hit(wordHit)
  );

  logic [1:0][HALF_W-1:0] halfRes;
  logic [1:0]             halfHit;

  for (genvar h = 0; h < 2; h++) begin : gHalf
    sat_clamp_lane #(.W(HALF_W), .WID_W(WID_W)) uHalfLane (
      .val(opA[h*HALF_W +: HALF_W]), .width(satWidth),
      .isSigned(strobe.clampSigned),
      .res(halfRes[h]), .hit(halfHit[h])
    );
  end

  always_comb begin
    result = opA;
    satHit = 1'b0;
    if (strobe.selSAdd) begin
      result = sAddOvf ? signLim : addFull[MSB:0];
      satHit = sAddOvf;
    end else if (strobe.selSSub) begin
      result = sSubOvf ? signLim : subFull[MSB:0];
      satHit = sSubOvf;
    end else if (strobe.selDbl) begin
      result = dblHi ? MAX_S : (dblLo ? MIN_S : {opA[MSB-1:0], 1'b0});
      satHit = dblHi | dblLo;
    end else if (strobe.selUAdd) begin
      result = addFull[DATA_W] ? '1 : addFull[MSB:0];
      satHit = addFull[DATA_W];
    end else if (strobe.selUSub) begin
      result = subFull[DATA_W] ? '0 : subFull[MSB:0];
      satHit = subFull[DATA_W];
    end else if (strobe.selClamp) begin
      result = strobe.clampHalf ? halfRes : wordRes;
      satHit = strobe.clampHalf ? |halfHit : wordHit;
    end
  end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WID_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [WID_W-1:0]  satWidth,
  input  logic              stickyClr,
  output logic [DATA_W-1:0] result,
  output logic              sticky
);
  satStrobe_t strobe;
  logic       satHit;

  sat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .satHit(satHit),
    .stickyClr(stickyClr), .strobe(strobe), .sticky(sticky)
  );

  sat_dp #(.DATA_W(DATA_W), .WID_W(WID_W)) uDp (
    .strobe(strobe), .opA(opA), .opB(opB), .satWidth(satWidth),
    .result(result), .satHit(satHit)
  );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int DATA_W = 32,
  parameter int WID_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [WID_W-1:0]  satWidth,
  input logic              stickyClr,
  input logic [DATA_W-1:0] result,
  input logic              sticky
);
  localparam int M = DATA_W - 1;

  a_r1_add_keeps_sign: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd1 && opA[M] == opB[M]) |-> result[M] == opA[M]);
  a_r2_sub_keeps_sign: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd2 && opA[M] != opB[M]) |-> result[M] == opA[M]);
  a_r4_uadd_not_below: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd4) |-> result >= opA);
  a_r5_usub_not_above: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd5) |-> result <= opA);
  a_r8_half_zero_width: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd9 && satWidth == '0) |-> result == '0);
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    (sticky && !stickyClr) |=> sticky);
  a_r9_sticky_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stickyClr && opCode == 4'd0) |=> !sticky);
  a_r10_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd0) |-> result == opA);
  a_r10_pass_no_set: assert property (@(posedge clk) disable iff (!rstN)
    (!sticky && opCode == 4'd0) |=> !sticky);
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W), .WID_W(WID_W)) uChk (
  .clk(clk), .rstN(rstN), .opCode(opCode), .opA(opA), .opB(opB),
  .satWidth(satWidth), .stickyClr(stickyClr), .result(result), .sticky(sticky)
);

// File: tb/sat_alu_test.sv
module sat_alu_test;
  localparam int CLK_P  = 10;
  localparam int DW     = 8;
  localparam int HW     = DW / 2;
  localparam int WW     = $clog2(DW) + 1;
  localparam int WD_MAX = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [3:0]    opCode = '0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [WW-1:0] satWidth = '0;
  logic          stickyClr = 1'b0;
  logic [DW-1:0] result;
  logic          sticky;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  modelSticky = 1'b0;

  sat_alu #(.DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opA(opA), .opB(opB),
    .satWidth(satWidth), .stickyClr(stickyClr), .result(result), .sticky(sticky)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_MAX) begin
      errors++;
      $display("FAIL R9 watchdog actual %0d expected <= %0d cycles", cycles, WD_MAX);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tagOf(int op);
    case (op)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";
      8, 9: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic int sx(int v, int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  function automatic void limit(int v, int lo, int hi, output int r, output bit h);
    h = 1'b0; r = v;
    if (v > hi) begin r = hi; h = 1'b1; end
    else if (v < lo) begin r = lo; h = 1'b1; end
  endfunction

  function automatic void clampModel(int v, int w, int cap, bit sgn, output int r, output bit h);
    int n;
    n = (w > cap) ? cap : w;
    if (sgn && n == 0) n = 1;
    if (sgn) limit(v, -(1 << (n-1)), (1 << (n-1)) - 1, r, h);
    else     limit(v, 0, (1 << n) - 1, r, h);
  endfunction

  function automatic void model(int op, int a, int b, int w, output int r, output bit h);
    int sa, sb, rl, rh, full, lim;
    bit hl, hh;
    full = 1 << DW;
    lim  = 1 << (DW-2);
    sa = sx(a, DW); sb = sx(b, DW);
    r = a; h = 1'b0;
    case (op)
      1: limit(sa + sb, -(full/2), full/2 - 1, r, h);
      2: limit(sa - sb, -(full/2), full/2 - 1, r, h);
      3: begin
        r = 2 * sa; h = (sa >= lim) || (sa <= -lim);
        if (sa >= lim) r = full/2 - 1;
        else if (sa <= -lim) r = -(full/2);
      end
      4: limit(a + b, 0, full - 1, r, h);
      5: limit(a - b, 0, full - 1, r, h);
      6: clampModel(sa, w, DW, 1'b1, r, h);
      7: clampModel(sa, w, DW, 1'b0, r, h);
      8, 9: begin
        clampModel(sx(a % (1 << HW), HW), w, HW, op == 8, rl, hl);
        clampModel(sx(a >> HW, HW), w, HW, op == 8, rh, hh);
        r = ((rh & ((1 << HW) - 1)) << HW) | (rl & ((1 << HW) - 1));
        h = hl | hh;
      end
      default: begin r = a; h = 1'b0; end
    endcase
    r = r & (full - 1);
  endfunction

  // One vector per cycle: result checked mid-cycle, flag after the edge
  task automatic runVec(int op, int a, int b, int w, bit clr);
    int expR;
    bit expH;
    model(op, a, b, w, expR, expH);
    @(negedge clk);
    opCode = op[3:0]; opA = a[DW-1:0]; opB = b[DW-1:0];
    satWidth = w[WW-1:0]; stickyClr = clr;
    #1;
    check(int'(result) == expR, tagOf(op), int'(result), expR);
    modelSticky = expH ? 1'b1 : (clr ? 1'b0 : modelSticky);
    @(posedge clk);
    #1;
    check(sticky == modelSticky, (expH || clr) ? "R9" : "R9 hold", int'(sticky), int'(modelSticky));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(sticky == 1'b0, "R9 reset", int'(sticky), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R4 R5: operand sweep, clear held high
    for (int op = 1; op <= 5; op++) begin
      if (op == 3) continue;
      for (int a = 0; a < 256; a++)
        for (int bi = 0; bi <= 37; bi++)
          runVec(op, a, (bi == 37) ? 255 : bi * 7, 0, 1'b1);
    end
    // R3: doubling, every opA
    for (int a = 0; a < 256; a++) runVec(3, a, a, 0, 1'b1);
    // R6 R7 R8: every value at every width code
    for (int op = 6; op <= 9; op++)
      for (int w = 0; w < (1 << WW); w++)
        for (int a = 0; a < 256; a++)
          runVec(op, a, 0, w, 1'b1);
    // R10: pass opcodes ignore opB and width
    for (int a = 0; a < 256; a++) begin
      runVec(0, a, 255 - a, a % 16, 1'b1);
      runVec(10, a, a ^ 8'h5a, 3, 1'b1);
      runVec(15, a, 8'h80, 0, 1'b1);
    end
    // R9: set, hold through idle ops, set beats clear, then clear
    runVec(0, 0, 0, 0, 1'b1);
    runVec(4, 200, 100, 0, 1'b0);
    runVec(0, 5, 0, 0, 1'b0);
    runVec(6, 3, 0, 4, 1'b0);
    runVec(1, 127, 1, 0, 1'b1);
    runVec(12, 9, 0, 0, 1'b1);
    runVec(12, 9, 0, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule